// File: doc/BRIEF.md
# Split-Byte Conversion Result Read Port

This block sits between a 10-bit converter core and an 8-bit parallel host bus. When the core ends a conversion by dropping its busy status, the block captures the result in a holding register. A host then reads it with active-low chip-select and read strobes. The first access returns the upper eight bits. The next access returns the two remaining bits, placed at the top of the byte with zeros below them. Later accesses keep alternating between the two.

The byte phase goes back to the upper byte whenever busy rises. A host that wants only eight bits can therefore read once per conversion and never see the low bits. An access made while busy is high is flagged as invalid.

The bus is modelled as a registered data value plus an output enable for an external tri-state driver. All inputs are sampled on the block clock. Every output is registered.

Top module: `adcrd_port`

## Requirements
- R1: `bus_oe` is 1 exactly when `cs_n` and `rd_n` were both 0 two clock edges earlier; otherwise it is 0.
- R2: While `bus_oe` is 0, `bus_data` is all zeros.
- R3: The first access after a conversion places result bits [9:2] on `bus_data`.
- R4: The second access places result bits [1:0] on `bus_data` bits [7:6], with bits [5:0] equal to 0.
- R5: Further accesses keep alternating between the R3 byte and the R4 byte of the same result.
- R6: A rising edge of `busy` returns the phase to the upper byte, even if the previous access left it on the low byte.
- R7: `rd_invalid` is 1 during an access made while `busy` is high, and 0 during an access made while `busy` is low.
- R8: The result is captured on the falling edge of `busy`; changes on `conv_result` at any other time do not alter the data that is read.
- R9: The phase advances only at the end of an access, which is a rising edge of `rd_n` while `cs_n` is 0. Toggling `rd_n` with `cs_n` high does not advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select, active low |
| rd_n | input | 1 | Read strobe, active low |
| busy | input | 1 | Conversion in progress status from the core |
| conv_result | input | 10 | Conversion result from the core |
| bus_data | output | 8 | Byte presented to the host bus |
| bus_oe | output | 1 | Enable for the external tri-state driver |
| rd_invalid | output | 1 | Current access was made while busy was high |

## Verification
The assertions assume three things about the inputs:
- the strobes are synchronous to the clock and each level is held for at least two cycles;
- `cs_n` stays low across the rising edge of `rd_n` that ends an access;
- `conv_result` is stable in the cycle in which `busy` falls.

The stimulus keeps to these by changing inputs only on falling clock edges. It holds every strobe level for several cycles, and raises `cs_n` only a cycle after `rd_n` has risen. It also loads the result before releasing `busy`, and scrambles `conv_result` only afterwards, so that only the capture rule of R8 can explain the data read back.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
  typedef enum logic {
    PH_HI = 1'b0,
    PH_LO = 1'b1
  } phase_t;
endpackage

// File: rtl/adcrd_in_stage.sv
module adcrd_in_stage #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             busy,
  input  logic [RES_W-1:0] conv_result,
  output logic             access,
  output logic             acc_end,
  output logic             busy_q,
  output logic             busy_up,
  output logic             busy_dn,
  output logic [RES_W-1:0] res_q
);
  logic cs_q, rd_q, rd_d, busy_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b1;
      rd_q   <= 1'b1;
      rd_d   <= 1'b1;
      busy_q <= 1'b0;
      busy_d <= 1'b0;
      res_q  <= '0;
    end else begin
      cs_q   <= cs_n;
      rd_q   <= rd_n;
      rd_d   <= rd_q;
      busy_q <= busy;
      busy_d <= busy_q;
      res_q  <= conv_result;
    end
  end

  always_comb begin
    access  = !cs_q && !rd_q;
    acc_end = rd_q && !rd_d && !cs_q;
    busy_up = busy_q && !busy_d;
    busy_dn = !busy_q && busy_d;
  end

  // R9: an access end is the rising edge of the read strobe with select held low
  p_end_follows_access_r9: assert property (@(posedge clk) disable iff (rst)
    acc_end |-> $past(access));
endmodule

// File: rtl/adcrd_res_latch.sv
module adcrd_res_latch #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [RES_W-1:0] din,
  output logic [RES_W-1:0] hold
);
  always_ff @(posedge clk) begin
    if (rst)       hold <= '0;
    else if (load) hold <= din;
  end

  // R8: the held result changes only after a busy falling edge
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(hold));
endmodule

// File: rtl/adcrd_byte_sel.sv
module adcrd_byte_sel
  import adcrd_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             access,
  input  logic             acc_end,
  input  logic             busy_q,
  input  logic             busy_up,
  input  logic [RES_W-1:0] hold,
  output logic [BUS_W-1:0] bus_data,
  output logic             bus_oe,
  output logic             rd_invalid
);
  localparam int LO_W  = RES_W - BUS_W;
  localparam int PAD_W = BUS_W - LO_W;

  phase_t           phase;
  logic [BUS_W-1:0] byte_hi, byte_lo, byte_sel;

  always_ff @(posedge clk) begin
    if (rst)          phase <= PH_HI;
    else if (busy_up) phase <= PH_HI;
    else if (acc_end) phase <= (phase == PH_HI) ? PH_LO : PH_HI;
  end

  always_comb begin
    byte_hi  = hold[RES_W-1:LO_W];
    byte_lo  = {hold[LO_W-1:0], {PAD_W{1'b0}}};
    byte_sel = (phase == PH_LO) ? byte_lo : byte_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_data   <= '0;
      bus_oe     <= 1'b0;
      rd_invalid <= 1'b0;
    end else begin
      bus_oe     <= access;
      bus_data   <= access ? byte_sel : '0;
      rd_invalid <= access && busy_q;
    end
  end

  // R6: busy rising always brings the phase back to the upper byte
  p_phase_clear_r6: assert property (@(posedge clk) disable iff (rst)
    busy_up |=> phase == PH_HI);
  // R5: each completed access flips the phase when busy is not rising
  p_phase_flip_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_end && !busy_up) |=> phase != $past(phase));
  // R9: without an access end or busy rise the phase holds
  p_phase_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!acc_end && !busy_up) |=> $stable(phase));
  // R7: the invalid flag only accompanies a driven bus
  p_invalid_in_access_r7: assert property (@(posedge clk) disable iff (rst)
    rd_invalid |-> bus_oe);
endmodule

// File: rtl/adcrd_port.sv
module adcrd_port #(
  parameter int RES_W = 10,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             busy,
  input  logic [RES_W-1:0] conv_result,
  output logic [BUS_W-1:0] bus_data,
  output logic             bus_oe,
  output logic             rd_invalid
);
  logic             access, acc_end, busy_q, busy_up, busy_dn;
  logic [RES_W-1:0] res_q, hold;

  adcrd_in_stage #(.RES_W(RES_W)) in_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .busy(busy),
    .conv_result(conv_result), .access(access), .acc_end(acc_end),
    .busy_q(busy_q), .busy_up(busy_up), .busy_dn(busy_dn), .res_q(res_q)
  );

  adcrd_res_latch #(.RES_W(RES_W)) latch_i (
    .clk(clk), .rst(rst), .load(busy_dn), .din(res_q), .hold(hold)
  );

  adcrd_byte_sel #(.RES_W(RES_W), .BUS_W(BUS_W)) sel_i (
    .clk(clk), .rst(rst), .access(access), .acc_end(acc_end),
    .busy_q(busy_q), .busy_up(busy_up), .hold(hold),
    .bus_data(bus_data), .bus_oe(bus_oe), .rd_invalid(rd_invalid)
  );

  // R1: a registered access shows up as the driver enable one edge later
  p_enable_r1: assert property (@(posedge clk) disable iff (rst)
    access |=> bus_oe);
  // R2: the bus is quiet when not driven
  p_quiet_bus_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> bus_data == '0);
endmodule

// File: tb/adcrd_port_tb.sv
module adcrd_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, busy = 1'b0;
  logic [9:0] conv_result = '0;
  logic [7:0] bus_data;
  logic       bus_oe, rd_invalid;
  int         total = 0, bad = 0;
  bit         timed_out = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcrd_port dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .busy(busy),
    .conv_result(conv_result), .bus_data(bus_data), .bus_oe(bus_oe),
    .rd_invalid(rd_invalid)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // conversion: busy high, result shows up, busy falls, result is scrambled afterwards
  task automatic convert(input logic [9:0] v);
    busy = 1'b1; conv_result = ~v; wn(3);
    conv_result = v; wn(1);
    busy = 1'b0; wn(3);
    conv_result = v ^ 10'h2A5;   // R8: later changes must be ignored
    wn(1);
  endtask

  task automatic do_read(input string req, input int exp_data, input bit exp_inv);
    cs_n = 1'b0; rd_n = 1'b0; wn(3);
    chk("R1 oe", bus_oe, 1);
    chk(req, bus_data, exp_data);
    chk("R7 invalid", rd_invalid, exp_inv);
    rd_n = 1'b1; wn(1);
    cs_n = 1'b1; wn(3);
    chk("R1 oe off", bus_oe, 0);
    chk("R2 bus zero", bus_data, 0);
  endtask

  task automatic run_all();
    wn(3);
    chk("R1 reset oe", bus_oe, 0);
    chk("R2 reset data", bus_data, 0);
    chk("R7 reset invalid", rd_invalid, 0);
    rst = 1'b0; wn(2);
    // exhaustive sweep over all result values
    for (int v = 0; v < 1024; v++) begin
      convert(10'(v));
      do_read("R3 hi", v >> 2, 1'b0);
      do_read("R4 lo", (v & 3) << 6, 1'b0);
      if ((v % 64) == 0) begin
        do_read("R5 hi again", v >> 2, 1'b0);
        do_read("R5 lo again", (v & 3) << 6, 1'b0);
      end
    end
    // R6: single read, then new conversion restarts on the upper byte
    convert(10'h3C7);
    do_read("R6 hi", 10'h3C7 >> 2, 1'b0);
    convert(10'h1B2);
    do_read("R6 hi after busy", 10'h1B2 >> 2, 1'b0);
    do_read("R6 lo", (10'h1B2 & 3) << 6, 1'b0);
    // R9: rd toggling with cs high: no drive, no advance
    convert(10'h2D9);
    do_read("R9 hi", 10'h2D9 >> 2, 1'b0);
    for (int k = 0; k < 3; k++) begin
      rd_n = 1'b0; wn(3);
      chk("R9 no oe", bus_oe, 0);
      rd_n = 1'b1; wn(3);
    end
    do_read("R9 lo kept", (10'h2D9 & 3) << 6, 1'b0);
    // R7: access during busy flagged invalid
    busy = 1'b1; wn(3);
    cs_n = 1'b0; rd_n = 1'b0; wn(3);
    chk("R7 invalid busy", rd_invalid, 1);
    chk("R1 oe busy", bus_oe, 1);
    rd_n = 1'b1; wn(1); cs_n = 1'b1; wn(3);
    chk("R7 invalid cleared", rd_invalid, 0);
    busy = 1'b0; wn(3);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    if (timed_out) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule